// File: doc/BRIEF.md
# DMA Request Router

This block sits between sixteen peripheral request lines and two consumers: the interrupt controller and a DMA engine. A per-channel enable register decides where each request goes. If a channel's enable bit is clear, the request appears on that channel's interrupt output. If it is set, the request appears on the DMA start output instead. A request never drives both outputs at once.

When the DMA engine reports that a channel's byte count has reached zero, the block clears that channel's enable bit. Later requests on that channel then fall back to interrupts without software action.

Channel 7 carries the serial receiver. It also has a stop-status flag, kept by a small state machine with two states, `STOP_IDLE` and `STOP_HELD`:
- Transition `ARM_STOP` (`STOP_IDLE` to `STOP_HELD`) is taken when the stop request input is high while channel 7 is enabled.
- Transition `SW_RELEASE` (`STOP_HELD` to `STOP_IDLE`) is taken when software writes 0 to the flag's bit and no stop request arrives in the same cycle.
- In `STOP_HELD`, channel 7 may not start DMA, and its requests are routed to the interrupt output.

Software sees three byte-wide registers with zero-wait-state reads:
- Address 0: enable bits for channels 7..0.
- Address 1: enable bits for channels 15..8.
- Address 2: stop status, with the flag in bit 7.

Top module: `dma_req_router`

## Requirements
- R1: After reset, all three registers read 0x00, and no DMA start output is high.
- R2: For a channel whose enable bit is 0, `irq_out[i]` equals `periph_req[i]` and `dma_start[i]` is 0.
- R3: For a channel whose enable bit is 1, `dma_start[i]` equals `periph_req[i]` and `irq_out[i]` is 0. The exception is given in R10.
- R4: A write at address 0 loads enable bits 7..0 from `bus_wdata[7:0]`, and a write at address 1 loads enable bits 15..8. Reads at these addresses return the bits in the same positions. A write at address 3 changes no register, and a read there returns 0x00.
- R5: A `cnt_zero[i]` pulse clears enable bit i at the next clock edge. From then on, requests on channel i go to `irq_out[i]`.
- R6: If `cnt_zero[i]` and a write of 1 to enable bit i occur in the same cycle, the bit ends up 0.
- R7: `stop_req` high while enable bit 7 is 1 sets status bit 7 (address 2 reads 0x80). `stop_req` high while enable bit 7 is 0 is ignored.
- R8: Status bits 6..0 always read 0. A software write cannot set status bit 7 from 0, and writing 1 to bit 7 leaves it unchanged.
- R9: Writing 0 to status bit 7 clears it at the next edge. If `stop_req` is accepted in the same cycle, the bit stays 1.
- R10: While status bit 7 is 1, `dma_start[7]` stays 0, and `irq_out[7]` follows `periph_req[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| periph_req | input | 16 | Peripheral request lines |
| irq_out | output | 16 | Requests routed to the interrupt controller |
| dma_start | output | 16 | Requests routed to the DMA engine |
| cnt_zero | input | 16 | Per-channel byte-count-reached-zero pulses |
| stop_req | input | 1 | Stop request for the serial receive channel |

## Verification
The assertions check the following properties on every cycle:
- Each request lands on exactly one output, which covers R2 and R3.
- A count-zero pulse always leaves its enable bit cleared, which covers R5.
- A stop is never recorded without a stop request, which covers R8.
- An accepted stop always wins over a clear, which covers R9.
- Channel 7 never starts DMA while halted, which covers R10.

Some behaviour is visible only through the bench's scenarios and its reference model:
- Byte-lane placement of the enable bits.
- Ignored writes at the spare address.
- The stop request being ignored while channel 7 is disabled.
- Readback values across the sequences.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
    typedef enum logic {
        STOP_IDLE = 1'b0,
        STOP_HELD = 1'b1
    } stop_st_e;
endpackage

// File: rtl/dmar_regbus.sv
module dmar_regbus #(
    parameter int N_CH   = 16,
    parameter int DW     = 8,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic                  wdata_msb,
    input  logic [N_CH-1:0]       en_q,
    input  logic                  halted,
    output logic [N_CH/DW-1:0]    wr_en_byte,
    output logic                  stat_clr,
    output logic [DW-1:0]         rdata
);
    localparam int N_BYTES = N_CH / DW;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_BYTES);

    for (genvar b = 0; b < N_BYTES; b++) begin : g_wdec
        assign wr_en_byte[b] = wr && (addr == ADDR_W'(b));
    end

    assign stat_clr = wr && (addr == STAT_ADDR) && !wdata_msb;

    always_comb begin
        rdata = '0;
        for (int b = 0; b < N_BYTES; b++) begin
            if (addr == ADDR_W'(b)) rdata = en_q[b*DW +: DW];
        end
        if (addr == STAT_ADDR) rdata = {halted, {(DW-1){1'b0}}};
    end
endmodule

// File: rtl/dmar_enable_bank.sv
module dmar_enable_bank #(
    parameter int N_CH = 16,
    parameter int DW   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CH/DW-1:0]  wr_en_byte,
    input  logic [DW-1:0]       wdata,
    input  logic [N_CH-1:0]     cnt_zero,
    output logic [N_CH-1:0]     en_q
);
    for (genvar i = 0; i < N_CH; i++) begin : g_bit
        localparam int BYTE_IDX = i / DW;
        localparam int BIT_IDX  = i % DW;
        always_ff @(posedge clk) begin
            if (!rst_n)                  en_q[i] <= 1'b0;
            else if (cnt_zero[i])        en_q[i] <= 1'b0;
            else if (wr_en_byte[BYTE_IDX]) en_q[i] <= wdata[BIT_IDX];
        end
    end
endmodule

// File: rtl/dmar_stop_fsm.sv
module dmar_stop_fsm
    import dmar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic ch_en,
    input  logic clr,
    output logic halted
);
    stop_st_e state_q, state_d;
    logic     accept;

    assign accept = stop_req && ch_en;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STOP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STOP_IDLE: if (accept)          state_d = STOP_HELD;
            STOP_HELD: if (clr && !accept)  state_d = STOP_IDLE;
            default:                        state_d = STOP_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            STOP_HELD: halted = 1'b1;
            default:   halted = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmar_route.sv
module dmar_route #(
    parameter int N_CH    = 16,
    parameter int STOP_CH = 7
) (
    input  logic [N_CH-1:0] periph_req,
    input  logic [N_CH-1:0] en_q,
    input  logic            halted,
    output logic [N_CH-1:0] irq_out,
    output logic [N_CH-1:0] dma_start
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic to_dma;
        if (i == STOP_CH) begin : g_gated
            assign to_dma = en_q[i] && !halted;
        end else begin : g_plain
            assign to_dma = en_q[i];
        end
        assign dma_start[i] = periph_req[i] && to_dma;
        assign irq_out[i]   = periph_req[i] && !to_dma;
    end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router #(
    parameter int N_CH    = 16,
    parameter int DW      = 8,
    parameter int ADDR_W  = 2,
    parameter int STOP_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N_CH-1:0]   periph_req,
    output logic [N_CH-1:0]   irq_out,
    output logic [N_CH-1:0]   dma_start,
    input  logic [N_CH-1:0]   cnt_zero,
    input  logic              stop_req
);
    localparam int N_BYTES = N_CH / DW;

    logic [N_CH-1:0]    en_q;
    logic [N_BYTES-1:0] wr_en_byte;
    logic               stat_clr;
    logic               halted;

    dmar_regbus #(.N_CH(N_CH), .DW(DW), .ADDR_W(ADDR_W)) u_regbus (
        .addr(bus_addr), .wr(bus_wr), .wdata_msb(bus_wdata[DW-1]),
        .en_q(en_q), .halted(halted),
        .wr_en_byte(wr_en_byte), .stat_clr(stat_clr), .rdata(bus_rdata)
    );

    dmar_enable_bank #(.N_CH(N_CH), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_byte(wr_en_byte),
        .wdata(bus_wdata), .cnt_zero(cnt_zero), .en_q(en_q)
    );

    dmar_stop_fsm u_stop (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
        .ch_en(en_q[STOP_CH]), .clr(stat_clr), .halted(halted)
    );

    dmar_route #(.N_CH(N_CH), .STOP_CH(STOP_CH)) u_route (
        .periph_req(periph_req), .en_q(en_q), .halted(halted),
        .irq_out(irq_out), .dma_start(dma_start)
    );
endmodule

// File: rtl/dmar_checker.sv
module dmar_checker #(
    parameter int N_CH    = 16,
    parameter int STOP_CH = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] periph_req,
    input logic [N_CH-1:0] irq_out,
    input logic [N_CH-1:0] dma_start,
    input logic [N_CH-1:0] cnt_zero,
    input logic            stop_req,
    input logic [N_CH-1:0] en_q,
    input logic            halted
);
    // R2 / R3: each request on exactly one output
    a_r2_one_sink: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & dma_start) == '0) && ((irq_out | dma_start) == periph_req));

    // R5: a count-zero pulse leaves its enable bit cleared
    a_r5_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero != '0) |=> ((en_q & $past(cnt_zero)) == '0));

    // R8: no stop recorded without a stop request
    a_r8_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !stop_req) |=> !halted);

    // R9: an accepted stop always wins
    a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && en_q[STOP_CH]) |=> halted);

    // R10: no DMA start on the stop channel while halted
    a_r10_ch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!dma_start[STOP_CH] && (irq_out[STOP_CH] == periph_req[STOP_CH])));
endmodule

bind dma_req_router dmar_checker #(.N_CH(N_CH), .STOP_CH(STOP_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .irq_out(irq_out),
    .dma_start(dma_start), .cnt_zero(cnt_zero), .stop_req(stop_req),
    .en_q(en_q), .halted(halted)
);

// File: tb/dma_req_router_bench.sv
module dma_req_router_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] periph_req = '0;
    logic [15:0] irq_out, dma_start;
    logic [15:0] cnt_zero = '0;
    logic        stop_req = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_en = '0;
    bit          m_halt = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_req_router u_dma_req_router (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
        .irq_out(irq_out), .dma_start(dma_start), .cnt_zero(cnt_zero),
        .stop_req(stop_req)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] route_dma();
        logic [15:0] r = m_en;
        if (m_halt) r[7] = 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] read_model(input logic [1:0] a);
        case (a)
            2'd0:    return m_en[7:0];
            2'd1:    return m_en[15:8];
            2'd2:    return {m_halt, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    // one cycle: drive, compare outputs, then advance the model at the edge
    task automatic step(input string tag, input logic [1:0] a, input logic w,
                        input logic [7:0] d, input logic [15:0] rq,
                        input logic [15:0] cz, input logic sp);
        logic [15:0] nen;
        bit          nhalt;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d;
        periph_req = rq; cnt_zero = cz; stop_req = sp;
        #2;
        chk(tag, "dma_start", dma_start, rq & route_dma());
        chk(tag, "irq_out", irq_out, rq & ~route_dma());
        chk(tag, "rdata", {8'h00, bus_rdata}, {8'h00, read_model(a)});
        nen = m_en;
        if (w && a == 2'd0) nen[7:0]  = d;
        if (w && a == 2'd1) nen[15:8] = d;
        nen = nen & ~cz;
        nhalt = m_halt;
        if (sp && m_en[7])            nhalt = 1'b1;
        else if (w && a == 2'd2 && !d[7]) nhalt = 1'b0;
        @(posedge clk);
        m_en = nen;
        m_halt = nhalt;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step("R1", 2'd0, 0, 8'h00, 16'hFFFF, 16'h0, 0);
        step("R1", 2'd1, 0, 8'h00, 16'h0, 16'h0, 0);
        step("R1", 2'd2, 0, 8'h00, 16'h0, 16'h0, 0);
        // R2: disabled channels route to interrupts
        step("R2", 2'd0, 0, 8'h00, 16'hA5C3, 16'h0, 0);
        // R4: byte lanes and readback
        step("R4", 2'd0, 1, 8'h5A, 16'h0, 16'h0, 0);
        step("R4", 2'd1, 1, 8'hC3, 16'h0, 16'h0, 0);
        step("R4", 2'd0, 0, 8'h00, 16'h0, 16'h0, 0);
        step("R4", 2'd3, 1, 8'hFF, 16'h0, 16'h0, 0);
        step("R4", 2'd1, 0, 8'h00, 16'h0, 16'h0, 0);
        step("R4", 2'd3, 0, 8'h00, 16'h0, 16'h0, 0);
        // R3: enabled channels route to DMA
        step("R3", 2'd0, 0, 8'h00, 16'hFFFF, 16'h0, 0);
        step("R3", 2'd1, 0, 8'h00, 16'h3C3C, 16'h0, 0);
        // R5: count-zero clears enable
        step("R5", 2'd0, 0, 8'h00, 16'h0, 16'h4002, 0);
        step("R5", 2'd1, 0, 8'h00, 16'hFFFF, 16'h0, 0);
        // R6: count-zero beats write of 1
        step("R6", 2'd0, 1, 8'hFF, 16'h0, 16'h0081, 0);
        step("R6", 2'd0, 0, 8'h00, 16'hFFFF, 16'h0, 0);
        // R7: stop ignored with channel 7 disabled
        step("R7", 2'd2, 0, 8'h00, 16'h0, 16'h0, 1);
        step("R7", 2'd2, 0, 8'h00, 16'h0080, 16'h0, 0);
        step("R7", 2'd0, 1, 8'h80, 16'h0, 16'h0, 0);
        step("R7", 2'd2, 0, 8'h00, 16'h0080, 16'h0, 1);
        // R8 / R10: status readback, no software set
        step("R8", 2'd2, 1, 8'hFF, 16'h0080, 16'h0, 0);
        step("R10", 2'd2, 0, 8'h00, 16'h0080, 16'h0, 0);
        // R9: hardware set wins over clear, then clear works
        step("R9", 2'd2, 1, 8'h00, 16'h0080, 16'h0, 1);
        step("R9", 2'd2, 1, 8'h00, 16'h0080, 16'h0, 0);
        step("R9", 2'd2, 0, 8'h00, 16'h0080, 16'h0, 0);
        // R8: with flag clear, writing 1 does not set it
        step("R8", 2'd2, 1, 8'h80, 16'h0, 16'h0, 0);
        step("R8", 2'd2, 0, 8'h00, 16'h0080, 16'h0, 0);
        // R3: mixed pseudo-random traffic
        begin
            logic [31:0] lf = 32'hACE1_1357;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                step("R3", lf[1:0], lf[2], lf[15:8], lf[31:16],
                     (lf[5:3] == 3'd0) ? {lf[15:0] & lf[31:16]} : 16'h0,
                     lf[6] & lf[7]);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule